// File: doc/BRIEF.md
# Bidirectional Row Scan Shifter

This block is the row-select side of a dot-matrix display driver. A one-bit scan token enters on one cascade port and moves one stage along a chain of row stages on each line strobe. It leaves on the opposite cascade port, so several devices can be chained into one tall column of rows. The direction input sets which port is the entry and which way the token travels. A split input divides the chain into two half-length chains that run side by side. The second half-chain is fed from its own extra token input.

Every row stage is combined with the frame polarity and an active-low blanking input to form a 2-bit drive-level code per channel. The analog level switches downstream use this code. The block runs on a single system clock. The line strobe arrives as a one-cycle `step` enable. All stages are registers with synchronous active-high reset. The drive codes are registered once more.

Top module: `row_scan_top`

## Requirements
- R1: While `rst` is high, on each clock all row stages clear, every drive code becomes 2'b00 and both cascade outputs read 0.
- R2: In a clock without `step`, no row stage changes, whatever the token inputs do.
- R3: With `split`=0 and `dir`=1, each `step` moves the token from channel k to channel k+1. Channel 0 loads `tok_a_in`, and `tok_b_out` shows channel N-1.
- R4: With `split`=0 and `dir`=0, each `step` moves the token from channel k to channel k-1. Channel N-1 loads `tok_b_in`, and `tok_a_out` shows channel 0.
- R5: With `split`=1 and `dir`=0, channels N-1 down to N/2 form one chain fed by `tok_b_in`. Channels N/2-1 down to 0 form a second chain fed by `tok_x_in`. `tok_a_out` shows channel 0.
- R6: With `split`=1 and `dir`=1, channels 0 up to N/2-1 form one chain fed by `tok_a_in`. Channels N/2 up to N-1 form a second chain fed by `tok_x_in`. `tok_b_out` shows channel N-1.
- R7: With `blank_n`=1, channel i's code is {frame, stage i}. 2'b00 is frame low and unselected, 2'b01 is frame low and selected, 2'b10 is frame high and unselected, and 2'b11 is frame high and selected.
- R8: With `blank_n`=0, every channel code becomes 2'b11, whatever the stages and the frame.
- R9: The cascade output on the entry side of the current direction is held at 0. The active cascade output changes in the same clock as the stage it shows.
- R10: A drive code reflects the stages, `frame` and `blank_n` as they stood at the previous clock edge, one register after the stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Line strobe, one shift per clock where high |
| dir | input | 1 | 1: token moves toward higher channels; 0: toward lower |
| split | input | 1 | 1: two half-length chains; 0: one full chain |
| frame | input | 1 | Frame polarity |
| blank_n | input | 1 | Active-low blanking |
| tok_a_in | input | 1 | Low-side cascade token input (used when dir=1) |
| tok_b_in | input | 1 | High-side cascade token input (used when dir=0) |
| tok_x_in | input | 1 | Token input of the second half-chain in split mode |
| tok_a_out | output | 1 | Low-side cascade token output (active when dir=0) |
| tok_b_out | output | 1 | High-side cascade token output (active when dir=1) |
| drive_code | output | 2*N | Per-channel drive code; channel i at bits [2i+1:2i] |

## Verification
The bench builds the block with 8 channels. That makes each half-chain 4 stages long. A sequence of two dozen pseudo-random token bits can then fill, flush and refill both chains in every one of the four direction and split combinations. At that size the whole code vector can be checked after every strobe against an arithmetic model. The model walks each chain by position. The bench also toggles the frame polarity and the blanking on the same strobes, so all four code values and the forced code appear in every mode.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;

  typedef enum logic [1:0] {
    LVL_LOW_IDLE  = 2'b00,
    LVL_LOW_SEL   = 2'b01,
    LVL_HIGH_IDLE = 2'b10,
    LVL_HIGH_SEL  = 2'b11
  } level_t;

  localparam int LEVEL_W = 2;

  function automatic level_t encode_level(input logic frame, input logic sel,
                                          input logic blank_n);
    level_t lv;
    if (!blank_n)   lv = LVL_HIGH_SEL;
    else if (frame) lv = sel ? LVL_HIGH_SEL : LVL_HIGH_IDLE;
    else            lv = sel ? LVL_LOW_SEL  : LVL_LOW_IDLE;
    return lv;
  endfunction

endpackage

// File: rtl/row_shift_core.sv
module row_shift_core #(
  parameter int N = 160
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         dir,
  input  logic         split,
  input  logic         feed_a,
  input  logic         feed_b,
  input  logic         feed_x,
  output logic [N-1:0] stage_q
);
  localparam int H = N / 2;

  logic [N-1:0] up_src;
  logic [N-1:0] dn_src;
  logic [N-1:0] stage_d;

  for (genvar i = 0; i < N; i++) begin : g_stage
    // source when the token moves toward higher channels
    if (i == 0) begin : g_up_head
      assign up_src[i] = feed_a;
    end else if (i == H) begin : g_up_seam
      assign up_src[i] = split ? feed_x : stage_q[i-1];
    end else begin : g_up_mid
      assign up_src[i] = stage_q[i-1];
    end
    // source when the token moves toward lower channels
    if (i == N - 1) begin : g_dn_head
      assign dn_src[i] = feed_b;
    end else if (i == H - 1) begin : g_dn_seam
      assign dn_src[i] = split ? feed_x : stage_q[i+1];
    end else begin : g_dn_mid
      assign dn_src[i] = stage_q[i+1];
    end
    assign stage_d[i] = dir ? up_src[i] : dn_src[i];
  end

  always_ff @(posedge clk) begin
    if (rst)       stage_q <= '0;
    else if (step) stage_q <= stage_d;
  end

  // R1: reset clears every stage
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> stage_q == '0);

  // R2: no strobe, no movement
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(stage_q));

  // R3/R6: low-side entry loads channel 0 when moving upward
  p_entry_up_r3: assert property (@(posedge clk) disable iff (rst)
    (step && dir) |=> stage_q[0] == $past(feed_a));

  // R4/R5: high-side entry loads channel N-1 when moving downward
  p_entry_dn_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !dir) |=> stage_q[N-1] == $past(feed_b));

  // R6: in split mode the upper half-chain starts from the extra input
  p_seam_up_r6: assert property (@(posedge clk) disable iff (rst)
    (step && dir && split) |=> stage_q[H] == $past(feed_x));

  // R5: in split mode the lower half-chain starts from the extra input
  p_seam_dn_r5: assert property (@(posedge clk) disable iff (rst)
    (step && !dir && split) |=> stage_q[H-1] == $past(feed_x));

endmodule

// File: rtl/row_level_encoder.sv
module row_level_encoder
  import row_scan_pkg::*;
#(
  parameter int N = 160
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame,
  input  logic                 blank_n,
  input  logic [N-1:0]         sel,
  output logic [LEVEL_W*N-1:0] code_q
);
  logic [LEVEL_W*N-1:0] code_d;

  for (genvar i = 0; i < N; i++) begin : g_chan
    assign code_d[LEVEL_W*i +: LEVEL_W] = encode_level(frame, sel[i], blank_n);
  end

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else     code_q <= code_d;
  end

  // R8: blanking forces the high-selected code everywhere
  p_blank_forces_r8: assert property (@(posedge clk) disable iff (rst)
    !blank_n |=> code_q == {N{LVL_HIGH_SEL}});

  // R7/R10: channel 0 follows the frame and its stage one clock later
  p_chan0_track_r10: assert property (@(posedge clk) disable iff (rst)
    blank_n |=> code_q[1:0] == {$past(frame), $past(sel[0])});

  // R1: reset drives all codes to the low-idle value
  p_reset_code_r1: assert property (@(posedge clk) rst |=> code_q == '0);

endmodule

// File: rtl/row_cascade_port.sv
module row_cascade_port #(
  parameter int N = 160
) (
  input  logic         dir,
  input  logic [N-1:0] stage_q,
  output logic         tok_a_out,
  output logic         tok_b_out
);
  always_comb begin
    tok_a_out = 1'b0;
    tok_b_out = 1'b0;
    if (dir) tok_b_out = stage_q[N-1];
    else     tok_a_out = stage_q[0];
  end
endmodule

// File: rtl/row_scan_top.sv
module row_scan_top
  import row_scan_pkg::*;
#(
  parameter int N = 160
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic                 dir,
  input  logic                 split,
  input  logic                 frame,
  input  logic                 blank_n,
  input  logic                 tok_a_in,
  input  logic                 tok_b_in,
  input  logic                 tok_x_in,
  output logic                 tok_a_out,
  output logic                 tok_b_out,
  output logic [LEVEL_W*N-1:0] drive_code
);
  logic [N-1:0] stage_q;

  row_shift_core #(.N(N)) u_core (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .dir     (dir),
    .split   (split),
    .feed_a  (tok_a_in),
    .feed_b  (tok_b_in),
    .feed_x  (tok_x_in),
    .stage_q (stage_q)
  );

  row_cascade_port #(.N(N)) u_port (
    .dir       (dir),
    .stage_q   (stage_q),
    .tok_a_out (tok_a_out),
    .tok_b_out (tok_b_out)
  );

  row_level_encoder #(.N(N)) u_enc (
    .clk     (clk),
    .rst     (rst),
    .frame   (frame),
    .blank_n (blank_n),
    .sel     (stage_q),
    .code_q  (drive_code)
  );

  // R9: the entry-side cascade output stays low
  p_idle_port_r9: assert property (@(posedge clk) disable iff (rst)
    dir |-> !tok_a_out);
  p_idle_port_b_r9: assert property (@(posedge clk) disable iff (rst)
    !dir |-> !tok_b_out);

  // R1: cascade outputs are low right after a reset clock
  p_reset_port_r1: assert property (@(posedge clk)
    rst |=> (!tok_a_out && !tok_b_out));

endmodule

// File: tb/sim_row_scan_top.sv
module sim_row_scan_top;
  localparam int N = 8;
  localparam int H = N / 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, step, dir, split, frame, blank_n;
  logic tok_a_in, tok_b_in, tok_x_in, tok_a_out, tok_b_out;
  logic [2*N-1:0] drive_code;

  row_scan_top #(.N(N)) u0 (
    .clk(clk), .rst(rst), .step(step), .dir(dir), .split(split),
    .frame(frame), .blank_n(blank_n), .tok_a_in(tok_a_in),
    .tok_b_in(tok_b_in), .tok_x_in(tok_x_in), .tok_a_out(tok_a_out),
    .tok_b_out(tok_b_out), .drive_code(drive_code)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [N-1:0] model;
  logic [7:0] lf;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pos_idx(input bit d, input bit s, input int c, input int p);
    if (!s) return d ? p : N - 1 - p;
    if (d) return c * H + p;
    return (c == 0) ? N - 1 - p : H - 1 - p;
  endfunction

  function automatic logic [2*N-1:0] exp_codes(input logic [N-1:0] m,
                                               input logic fr, input logic bl);
    logic [2*N-1:0] v;
    for (int i = 0; i < N; i++) v[2*i +: 2] = bl ? {fr, m[i]} : 2'b11;
    return v;
  endfunction

  task automatic model_shift(input logic a, input logic b, input logic x);
    logic [N-1:0] nw;
    int len, nch;
    nw = model;
    len = split ? H : N;
    nch = split ? 2 : 1;
    for (int c = 0; c < nch; c++)
      for (int p = 0; p < len; p++) begin
        if (p == 0) nw[pos_idx(dir, split, c, p)] = (c == 0) ? (dir ? a : b) : x;
        else nw[pos_idx(dir, split, c, p)] = model[pos_idx(dir, split, c, p - 1)];
      end
    model = nw;
  endtask

  task automatic step_once(input logic a, input logic b, input logic x,
                           input logic fr, input logic bl, input string req);
    logic [2*N-1:0] mid;
    @(negedge clk);
    tok_a_in = a; tok_b_in = b; tok_x_in = x;
    frame = fr; blank_n = bl; step = 1'b1;
    mid = exp_codes(model, fr, bl);
    @(negedge clk);
    step = 1'b0;
    chk("R10 code lags stages", drive_code, mid);
    model_shift(a, b, x);
    chk({req, " R9 tok_a_out"}, tok_a_out, dir ? 1'b0 : model[0]);
    chk({req, " R9 tok_b_out"}, tok_b_out, dir ? model[N-1] : 1'b0);
    @(negedge clk);
    chk({req, bl ? " R7 codes" : " R8 blank codes"}, drive_code, exp_codes(model, fr, bl));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 codes in reset", drive_code, '0);
    chk("R1 tok_a_out in reset", tok_a_out, 1'b0);
    chk("R1 tok_b_out in reset", tok_b_out, 1'b0);
    rst = 1'b0;
    model = '0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    string req;
    logic [2*N-1:0] held;
    rst = 1'b1; step = 1'b0; dir = 1'b1; split = 1'b0;
    frame = 1'b0; blank_n = 1'b1;
    tok_a_in = 1'b0; tok_b_in = 1'b0; tok_x_in = 1'b0;
    lf = 8'hA5;
    model = '0;
    do_reset();
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 2; s++) begin
        @(negedge clk);
        dir = d[0]; split = s[0];
        do_reset();
        @(negedge clk);
        chk("R1 codes after reset", drive_code, exp_codes('0, frame, blank_n));
        if (!s[0]) req = d[0] ? "R3" : "R4";
        else       req = d[0] ? "R6" : "R5";
        for (int k = 0; k < 24; k++) begin
          lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
          step_once(lf[0], lf[2], lf[5], k[0] ^ k[2], (k % 7) != 3, req);
        end
        // R2: token inputs toggle with no strobe
        held = drive_code;
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          tok_a_in = ~tok_a_in; tok_b_in = ~tok_b_in; tok_x_in = ~tok_x_in;
        end
        @(negedge clk);
        chk("R2 codes held without step", drive_code, held);
        chk("R2 tok_a_out held", tok_a_out, dir ? 1'b0 : model[0]);
        chk("R2 tok_b_out held", tok_b_out, dir ? model[N-1] : 1'b0);
      end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule